// File: doc/BRIEF.md
# Linked Multi-Channel Packet Filter

This block picks packets out of a multiplexed packet stream for eight independent storage channels. After error correction, an upstream stage presents one header per packet. The header carries a 10-bit packet address, a 4-bit continuity index, an 8-bit packet type, a 36-bit extension field and a 2-bit location tag. Each channel compares the header against its own programmed conditions. One clock later it raises a store strobe toward its buffer when every condition holds.

A channel can chain continuation packets to a first sync packet. Once the sync packet is taken, the channel relaxes its match rules. It can stop checking the continuity index, or it can switch the type compare to a second value. A page bit decides whether the extension is checked on every packet or only on the sync packet. A per-channel flag shows that linking has started. Software programs the channels through a simple register-write port.

Top module: `link_pkt_filter`

## Requirements
- R1: After reset, every store strobe and every link flag is 0.
- R2: The register port writes channel `reg_chan` when `reg_wr` is 1. `reg_sel` chooses the register:
  - 0 is the address-base register: address in bits [9:0], continuity index in bits [13:10].
  - 1 is the extension value.
  - 2 is the extension mask.
  - 3 is control, with these fields:
    - [0] enable
    - [1] continuity link
    - [2] type link
    - [3] page
    - [5:4] location
    - [13:6] first type
    - [21:14] second type
  With no link active, an enabled channel raises its strobe in the cycle after a valid header only when address, continuity index, packet type (first type) and location all match.
- R3: An extension bit takes part in the compare only where its mask bit is 1. A mask of all zeros accepts any extension.
- R4: A channel whose enable bit is 0 never raises its strobe.
- R5: When continuity link or type link is on, the first fully matching packet sets that channel's link flag. With both link bits off, the flag stays 0.
- R6: While continuity link is active, the continuity index of the header is not compared.
- R7: While type link is active, the packet type is compared against the second type and no longer against the first.
- R8: With the page bit at 0, the extension is checked on every packet. With it at 1, the extension is checked only until the link flag is set.
- R9: Writing a channel's control register clears its link flag. So does a disabled enable bit.
- R10: Channels act independently: each strobe and flag bit depends only on its own channel's registers and history.
- R11: No strobe is raised in a cycle that follows a cycle without a valid header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_chan | input | 3 | Channel being written |
| reg_sel | input | 2 | Register select (0 base, 1 ext value, 2 ext mask, 3 control) |
| reg_data | input | 36 | Write data |
| hdr_valid | input | 1 | Header present this cycle |
| hdr_addr | input | 10 | Packet address |
| hdr_ci | input | 4 | Continuity index |
| hdr_ptype | input | 8 | Packet type |
| hdr_ext | input | 36 | Address extension field |
| hdr_loc | input | 2 | Location tag |
| store_stb | output | 8 | Per-channel store strobe, one cycle after the header |
| link_active | output | 8 | Per-channel link-started flag |

## Verification
The bench goes after the moment a link starts. A design that updated its link state before judging the sync packet would compare the sync packet against the second type, or skip its continuity check, and so lose the sync packet itself. Extension checking under the page bit is driven with mismatching extensions after sync. A design with the page sense inverted would drop linked packets, or accept bad ones. Masks of all zeros and of a single bit expose a compare that ignores the mask. Control rewrites and disables in the middle of a link catch a flag that survives reprogramming.

// File: rtl/pktf_pkg.sv
package pktf_pkg;
  localparam int ADDR_W = 10;
  localparam int CI_W   = 4;
  localparam int PT_W   = 8;
  localparam int EXT_W  = 36;
  localparam int LOC_W  = 2;
  localparam int SEL_W  = 2;
  localparam int BASE_W = ADDR_W + CI_W;

  localparam logic [SEL_W-1:0] SEL_BASE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_EXTV = 2'd1;
  localparam logic [SEL_W-1:0] SEL_EXTM = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTL  = 2'd3;

  typedef struct packed {
    logic [PT_W-1:0]  pt2;
    logic [PT_W-1:0]  pt1;
    logic [LOC_W-1:0] loc;
    logic             page;
    logic             link_pt;
    logic             link_ci;
    logic             en;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

  // masked extension compare: only bits with a set mask bit matter
  function automatic logic ext_equal(input logic [EXT_W-1:0] ext,
                                     input logic [EXT_W-1:0] val,
                                     input logic [EXT_W-1:0] mask);
    return ((ext ^ val) & mask) == '0;
  endfunction

  // type value expected for the current link state
  function automatic logic [PT_W-1:0] type_target(input ctl_t c, input logic linked);
    return (linked && c.link_pt) ? c.pt2 : c.pt1;
  endfunction
endpackage

// File: rtl/pktf_chan_regs.sv
module pktf_chan_regs
  import pktf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [EXT_W-1:0]  data,
  output logic [ADDR_W-1:0] base_addr,
  output logic [CI_W-1:0]   base_ci,
  output logic [EXT_W-1:0]  ext_val,
  output logic [EXT_W-1:0]  ext_mask,
  output ctl_t              ctl,
  output logic              ctl_wr
);
  assign ctl_wr = wr && (sel == SEL_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      base_ci   <= '0;
      ext_val   <= '0;
      ext_mask  <= '0;
      ctl       <= '0;
    end else if (wr) begin
      case (sel)
        SEL_BASE: {base_ci, base_addr} <= data[BASE_W-1:0];
        SEL_EXTV: ext_val  <= data;
        SEL_EXTM: ext_mask <= data;
        default:  ctl      <= ctl_t'(data[CTL_W-1:0]);
      endcase
    end
  end
endmodule

// File: rtl/pktf_chan_match.sv
module pktf_chan_match
  import pktf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [CI_W-1:0]   hdr_ci,
  input  logic [PT_W-1:0]   hdr_ptype,
  input  logic [EXT_W-1:0]  hdr_ext,
  input  logic [LOC_W-1:0]  hdr_loc,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CI_W-1:0]   base_ci,
  input  logic [EXT_W-1:0]  ext_val,
  input  logic [EXT_W-1:0]  ext_mask,
  input  ctl_t              ctl,
  input  logic              ctl_wr,
  output logic              stb,
  output logic              linked
);
  logic hit_addr, hit_ci, hit_pt, hit_ext, hit_loc, hit_all;
  logic link_mode, sync_ev, clear_ev;

  assign link_mode = ctl.link_ci || ctl.link_pt;
  assign hit_addr  = hdr_addr == base_addr;
  assign hit_loc   = hdr_loc == ctl.loc;
  assign hit_ci    = (linked && ctl.link_ci) || (hdr_ci == base_ci);
  assign hit_pt    = hdr_ptype == type_target(ctl, linked);
  assign hit_ext   = (linked && ctl.page) || ext_equal(hdr_ext, ext_val, ext_mask);
  assign hit_all   = hdr_valid && ctl.en && hit_addr && hit_loc && hit_ci && hit_pt && hit_ext;
  assign sync_ev   = hit_all && link_mode && !linked;
  assign clear_ev  = ctl_wr || !ctl.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb    <= 1'b0;
      linked <= 1'b0;
    end else begin
      stb <= hit_all;
      if (clear_ev)     linked <= 1'b0;
      else if (sync_ev) linked <= 1'b1;
    end
  end

  // R11: a strobe always follows a valid header
  p_stb_after_hdr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stb |-> $past(hdr_valid));
  // R4: a disabled channel does not strobe
  p_off_no_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> !stb);
  // R9: a control write drops the link
  p_ctl_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !linked);
  // R5: the link starts only on a strobed packet
  p_link_on_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(linked) |-> stb);
  // R5: no link without a link mode
  p_link_needs_mode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    linked |-> link_mode);
endmodule

// File: rtl/link_pkt_filter.sv
module link_pkt_filter
  import pktf_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [CH_W-1:0]   reg_chan,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [EXT_W-1:0]  reg_data,
  input  logic              hdr_valid,
  input  logic [ADDR_W-1:0] hdr_addr,
  input  logic [CI_W-1:0]   hdr_ci,
  input  logic [PT_W-1:0]   hdr_ptype,
  input  logic [EXT_W-1:0]  hdr_ext,
  input  logic [LOC_W-1:0]  hdr_loc,
  output logic [NCH-1:0]    store_stb,
  output logic [NCH-1:0]    link_active
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic              wr_here;
    logic [ADDR_W-1:0] base_addr;
    logic [CI_W-1:0]   base_ci;
    logic [EXT_W-1:0]  ext_val;
    logic [EXT_W-1:0]  ext_mask;
    ctl_t              ctl;
    logic              ctl_wr;

    assign wr_here = reg_wr && (reg_chan == CH_W'(i));

    pktf_chan_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(wr_here), .sel(reg_sel), .data(reg_data),
      .base_addr(base_addr), .base_ci(base_ci), .ext_val(ext_val),
      .ext_mask(ext_mask), .ctl(ctl), .ctl_wr(ctl_wr)
    );

    pktf_chan_match u_match (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_addr(hdr_addr),
      .hdr_ci(hdr_ci), .hdr_ptype(hdr_ptype), .hdr_ext(hdr_ext), .hdr_loc(hdr_loc),
      .base_addr(base_addr), .base_ci(base_ci), .ext_val(ext_val),
      .ext_mask(ext_mask), .ctl(ctl), .ctl_wr(ctl_wr),
      .stb(store_stb[i]), .linked(link_active[i])
    );
  end

  // R1: quiet right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> (store_stb == '0) && (link_active == '0));
endmodule

// File: tb/link_pkt_filter_bench.sv
`timescale 1ns/1ps
module link_pkt_filter_bench;
  localparam int N = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_chan = '0;
  logic [1:0] reg_sel = '0;
  logic [35:0] reg_data = '0;
  logic hdr_valid = 1'b0;
  logic [9:0] hdr_addr = '0;
  logic [3:0] hdr_ci = '0;
  logic [7:0] hdr_ptype = '0;
  logic [35:0] hdr_ext = '0;
  logic [1:0] hdr_loc = '0;
  logic [N-1:0] store_stb, link_active;

  always #2.5 clk = ~clk;

  link_pkt_filter u_link_pkt_filter (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side copy of the programmed state
  logic [9:0]  m_addr [N];
  logic [3:0]  m_ci   [N];
  logic [7:0]  m_pt1  [N], m_pt2 [N];
  logic [1:0]  m_loc  [N];
  logic [35:0] m_ev   [N], m_em  [N];
  bit m_en [N], m_lci [N], m_lpt [N], m_pg [N], m_lk [N];
  logic [N-1:0] exp_stb = '0;

  function automatic bit would_take(int c, logic [9:0] a, logic [3:0] ci, logic [7:0] pt,
                                    logic [35:0] ex, logic [1:0] lc);
    logic [7:0] want;
    if (!m_en[c] || a != m_addr[c] || lc != m_loc[c]) return 0;
    if (!(m_lk[c] && m_lci[c]) && ci != m_ci[c]) return 0;
    want = (m_lk[c] && m_lpt[c]) ? m_pt2[c] : m_pt1[c];
    if (pt != want) return 0;
    if (!(m_lk[c] && m_pg[c]))
      for (int k = 0; k < 36; k++)
        if (m_em[c][k] && (ex[k] != m_ev[c][k])) return 0;
    return 1;
  endfunction

  function automatic logic [N-1:0] exp_links();
    logic [N-1:0] v;
    for (int c = 0; c < N; c++) v[c] = m_lk[c];
    return v;
  endfunction

  task automatic check(string tag);
    total++;
    if (store_stb !== exp_stb || link_active !== exp_links()) begin
      bad++;
      $display("FAIL %s stb=%h exp=%h link=%h exp=%h", tag, store_stb, exp_stb,
               link_active, exp_links());
    end
  endtask

  task automatic wr(int c, logic [1:0] s, logic [35:0] d);
    @(negedge clk);
    reg_wr = 1; reg_chan = 3'(c); reg_sel = s; reg_data = d;
    @(negedge clk);
    reg_wr = 0;
    exp_stb = '0;
    case (s)
      2'd0: begin m_addr[c] = d[9:0]; m_ci[c] = d[13:10]; end
      2'd1: m_ev[c] = d;
      2'd2: m_em[c] = d;
      default: begin
        m_en[c] = d[0]; m_lci[c] = d[1]; m_lpt[c] = d[2]; m_pg[c] = d[3];
        m_loc[c] = d[5:4]; m_pt1[c] = d[13:6]; m_pt2[c] = d[21:14]; m_lk[c] = 0;
      end
    endcase
  endtask

  task automatic ctl(int c, bit en, bit lci, bit lpt, bit pg, logic [1:0] lc,
                     logic [7:0] p1, logic [7:0] p2);
    wr(c, 2'd3, 36'({p2, p1, lc, pg, lpt, lci, en}));
  endtask

  task automatic send(string tag, logic [9:0] a, logic [3:0] ci, logic [7:0] pt,
                      logic [35:0] ex, logic [1:0] lc);
    @(negedge clk);
    hdr_valid = 1; hdr_addr = a; hdr_ci = ci; hdr_ptype = pt; hdr_ext = ex; hdr_loc = lc;
    for (int c = 0; c < N; c++) begin
      exp_stb[c] = would_take(c, a, ci, pt, ex, lc);
      if (exp_stb[c] && (m_lci[c] || m_lpt[c])) m_lk[c] = 1;
      if (!m_en[c]) m_lk[c] = 0;
    end
    @(negedge clk);
    hdr_valid = 0;
    check(tag);
    exp_stb = '0;
  endtask

  task automatic send_own(string tag, int c);
    send(tag, m_addr[c], m_ci[c], (m_lk[c] && m_lpt[c]) ? m_pt2[c] : m_pt1[c],
         m_ev[c], m_loc[c]);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired stb=%h exp=%h", store_stb, exp_stb);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd4711);
    for (int c = 0; c < N; c++) begin
      m_addr[c] = '0; m_ci[c] = '0; m_pt1[c] = '0; m_pt2[c] = '0; m_loc[c] = '0;
      m_ev[c] = '0; m_em[c] = '0; m_en[c] = 0; m_lci[c] = 0; m_lpt[c] = 0;
      m_pg[c] = 0; m_lk[c] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");

    for (int c = 0; c < N; c++) begin
      wr(c, 2'd0, 36'({4'(c + 3), 10'(c * 97 + 13)}));
      wr(c, 2'd1, 36'h5_A5A5_0F0F ^ 36'(c));
      wr(c, 2'd2, 36'h0_0000_FFFF);
      ctl(c, 1, 0, 0, 0, 2'(c), 8'(8'h20 + c), 8'(8'h60 + c));
    end

    // R2 plain match and single-field misses
    send_own("R2 exact", 0);
    send("R2 addr miss", m_addr[0] ^ 10'h200, m_ci[0], m_pt1[0], m_ev[0], m_loc[0]);
    send("R2 ci miss", m_addr[0], m_ci[0] ^ 4'h1, m_pt1[0], m_ev[0], m_loc[0]);
    send("R2 type miss", m_addr[0], m_ci[0], m_pt1[0] ^ 8'h80, m_ev[0], m_loc[0]);
    send("R2 loc miss", m_addr[0], m_ci[0], m_pt1[0], m_ev[0], m_loc[0] ^ 2'd1);
    @(negedge clk);
    check("R11 idle");

    // R3 mask handling
    send("R3 masked bit off", m_addr[0], m_ci[0], m_pt1[0], m_ev[0] ^ 36'h8_0000_0000, m_loc[0]);
    send("R3 masked bit on", m_addr[0], m_ci[0], m_pt1[0], m_ev[0] ^ 36'h0_0000_0001, m_loc[0]);
    wr(0, 2'd2, 36'h0);
    send("R3 zero mask", m_addr[0], m_ci[0], m_pt1[0], ~m_ev[0], m_loc[0]);
    wr(0, 2'd2, 36'h8_0000_0000);
    send("R3 top bit only", m_addr[0], m_ci[0], m_pt1[0], m_ev[0] ^ 36'h1, m_loc[0]);
    send("R3 top bit miss", m_addr[0], m_ci[0], m_pt1[0], m_ev[0] ^ 36'h8_0000_0000, m_loc[0]);

    // R4 disabled
    ctl(0, 0, 0, 0, 0, m_loc[0], m_pt1[0], m_pt2[0]);
    send("R4 disabled", m_addr[0], m_ci[0], m_pt1[0], m_ev[0], m_loc[0]);

    // R5 R6 continuity link on channel 1, and no link on channel 5
    ctl(1, 1, 1, 0, 0, m_loc[1], m_pt1[1], m_pt2[1]);
    send("R6 pre-sync ci miss", m_addr[1], m_ci[1] ^ 4'h2, m_pt1[1], m_ev[1], m_loc[1]);
    send_own("R5 sync ch1", 1);
    send("R6 linked ci ignored", m_addr[1], m_ci[1] ^ 4'h2, m_pt1[1], m_ev[1], m_loc[1]);
    send_own("R5 no-link ch5", 5);

    // R7 type link on channel 2
    ctl(2, 1, 0, 1, 0, m_loc[2], m_pt1[2], m_pt2[2]);
    send("R7 pre-sync pt2", m_addr[2], m_ci[2], m_pt2[2], m_ev[2], m_loc[2]);
    send("R7 sync on pt1", m_addr[2], m_ci[2], m_pt1[2], m_ev[2], m_loc[2]);
    send("R7 linked pt1 rejected", m_addr[2], m_ci[2], m_pt1[2], m_ev[2], m_loc[2]);
    send("R7 linked pt2 taken", m_addr[2], m_ci[2], m_pt2[2], m_ev[2], m_loc[2]);

    // R8 page bit
    ctl(3, 1, 1, 0, 1, m_loc[3], m_pt1[3], m_pt2[3]);
    ctl(4, 1, 1, 0, 0, m_loc[4], m_pt1[4], m_pt2[4]);
    send("R8 page1 sync bad ext", m_addr[3], m_ci[3], m_pt1[3], ~m_ev[3], m_loc[3]);
    send_own("R8 page1 sync", 3);
    send("R8 page1 linked bad ext", m_addr[3], m_ci[3], m_pt1[3], ~m_ev[3], m_loc[3]);
    send_own("R8 page0 sync", 4);
    send("R8 page0 linked bad ext", m_addr[4], m_ci[4], m_pt1[4], ~m_ev[4], m_loc[4]);

    // R9 clearing
    ctl(1, 1, 1, 0, 0, m_loc[1], m_pt1[1], m_pt2[1]);
    @(negedge clk);
    check("R9 rewrite clears");
    ctl(2, 0, 0, 1, 0, m_loc[2], m_pt1[2], m_pt2[2]);
    @(negedge clk);
    check("R9 disable clears");
    send("R9 relinked needs ci", m_addr[1], m_ci[1] ^ 4'h2, m_pt1[1], m_ev[1], m_loc[1]);

    // R10 random mix across channels
    for (int it = 0; it < 600; it++) begin
      int c;
      logic [9:0] a; logic [3:0] ci; logic [7:0] pt; logic [35:0] ex; logic [1:0] lc;
      c = int'($urandom % N);
      if ($urandom % 16 == 0) begin
        ctl(c, ($urandom % 8) != 0, $urandom % 2 == 1, $urandom % 2 == 1, $urandom % 2 == 1,
            2'($urandom), 8'($urandom), 8'($urandom));
        if ($urandom % 2 == 1) begin
          r = int'($urandom % 3);
          wr(c, 2'd2, r == 0 ? 36'h0 : r == 1 ? 36'hF_FFFF_FFFF : 36'({$urandom, $urandom}));
        end
      end else begin
        a  = ($urandom % 8 == 0) ? 10'($urandom) : m_addr[c];
        ci = ($urandom % 4 == 0) ? 4'($urandom) : m_ci[c];
        pt = ($urandom % 2 == 0) ? m_pt1[c] : ($urandom % 2 == 0) ? m_pt2[c] : 8'($urandom);
        ex = ($urandom % 4 == 0) ? 36'({$urandom, $urandom}) : m_ev[c];
        lc = ($urandom % 6 == 0) ? 2'($urandom) : m_loc[c];
        send("R10 random", a, ci, pt, ex, lc);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule